// File: doc/BRIEF.md
# Configurable TDM Audio Serializer

This block sits on the transmit side of an audio port. It takes parallel sample words through a valid/ready input and shifts them out one bit per bit clock as a framed serial stream. It also produces its own frame-sync pulse. The frame is divided into time slots. With one slot the block runs in burst mode, where a frame is sent only when a sample is waiting. With two to thirty-two slots it runs in TDM mode, where frames follow each other without a break.

Static configuration inputs set the following:
- the slot count;
- the slot width and the data width, each chosen independently;
- whether data is justified toward the slot's MSB end or its LSB end;
- whether bits are sent MSB or LSB first;
- how the unused slot bits are filled;
- how many bit clocks the first slot lags the frame-sync pulse.

A configuration that cannot be honoured raises an error flag and silences the outputs. A TDM slot for which no sample has arrived is sent as all zeros, and this sets a sticky underrun flag.

Top module: `tdm_serializer`

## Requirements
- R1: `cfg_slots` = 1 selects burst mode, and 2..32 selects TDM mode. In TDM mode, frames of `cfg_slots` × slot-width bits follow each other with no gap, and the slots are sent in index order.
- R2: Slot-width code c (0..6) gives a slot of 8+4·c bits, so one slot lasts exactly that many bit clocks.
- R3: Data-width code c (0..6) gives 8+4·c data bits, taken from the low bits of `s_data`.
- R4: With `cfg_right_just` = 0, the data fills the most significant end of the slot word. With `cfg_right_just` = 1, it fills the least significant end. The data keeps its own bit order inside the slot word.
- R5: With `cfg_lsb_first` = 0, the slot word is sent from its top bit down. With `cfg_lsb_first` = 1, it is sent from bit 0 up.
- R6: Slot bits not holding data take the value set by `cfg_pad_mode`: 0 gives zero, 1 gives one, 2 gives a copy of `s_data[cfg_pad_sel]`, and 3 gives zero.
- R7: `fsync` is high for exactly one bit clock. The first bit of slot 0 is sent `cfg_fs_delay` clocks after the `fsync` cycle, or in the same cycle when the delay is 0.
- R8: In burst mode, a frame starts only when `s_valid` is high. While no frame is running, `ser_out` and `fsync` stay low.
- R9: `s_ready` is high exactly in the cycle before the first bit of each slot. A word accepted in that cycle has its first formatted bit on `ser_out` in the next cycle.
- R10: A configuration is illegal when any of the following holds: a width code is 7, the data code exceeds the slot code, `cfg_slots` is 0 or above 32, or `cfg_fs_delay` is 3. From the next clock on, an illegal configuration sets `cfg_err` and holds `ser_out`, `fsync` and `s_ready` low. Once the configuration becomes legal again, the block restarts from idle.
- R11: In TDM mode, a slot that starts with no sample waiting is sent as all zeros. This sets `underrun`, which stays high until reset.
- R12: During reset, `ser_out`, `fsync`, `cfg_err` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slots | input | 6 | Slots per frame (1 = burst) |
| cfg_slot_w | input | 3 | Slot width code (8+4·code bits) |
| cfg_data_w | input | 3 | Data width code (8+4·code bits) |
| cfg_right_just | input | 1 | Data at the LSB end of the slot word |
| cfg_lsb_first | input | 1 | Send bit 0 of the slot word first |
| cfg_pad_mode | input | 2 | Fill for unused bits |
| cfg_pad_sel | input | 5 | Bit of `s_data` copied in fill mode 2 |
| cfg_fs_delay | input | 2 | Bit clocks from frame sync to first bit |
| s_valid | input | 1 | Sample word offered |
| s_data | input | 32 | Sample word, data in the low bits |
| s_ready | output | 1 | Sample word taken this cycle if valid |
| ser_out | output | 1 | Serial data |
| fsync | output | 1 | Frame-sync pulse |
| cfg_err | output | 1 | Illegal configuration |
| underrun | output | 1 | Sticky: a TDM slot went out empty |

## Verification
The hardest situation to reach is a TDM frame boundary with a one- or two-clock delay. In that case the next frame's sync pulse falls inside the last slot of the current frame, while that slot's final bits are still being sent. The delay-1 and delay-2 cases hit this overlap by running several complete frames with two and three slots and a continuous supply of samples. A delay-0, 32-slot run covers the wrap at the top slot index. A burst run holds the sample supply back between words, so that idle gaps alternate with restarts. A TDM run switches to an illegal configuration in the middle of a frame and then back, which checks both the abort and the restart from idle.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    localparam int SAMPLE_W   = 32;
    localparam int MAX_SLOTS  = 32;
    localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
    localparam int SLOT_CNT_W = SLOT_IDX_W + 1;
    localparam int BIT_IDX_W  = $clog2(SAMPLE_W) + 1;
    localparam int WCODE_W    = 3;
    localparam int DELAY_W    = 2;
    localparam int PAD_SEL_W  = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        PAD_ZERO  = 2'd0,
        PAD_ONE   = 2'd1,
        PAD_COPY  = 2'd2,
        PAD_SPARE = 2'd3
    } pad_mode_e;

    typedef struct packed {
        logic                  run;
        logic [DELAY_W-1:0]    lead;
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bitn;
        logic [SAMPLE_W-1:0]   img;
        logic                  sdo;
        logic                  fs;
        logic                  err;
        logic                  und;
    } ser_state_t;

    function automatic logic [BIT_IDX_W-1:0] code_to_width(input logic [WCODE_W-1:0] code);
        return BIT_IDX_W'(8) + BIT_IDX_W'({code, 2'b00});
    endfunction

endpackage

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
    import tdm_ser_pkg::*;
(
    input  logic [SLOT_CNT_W-1:0] slots_i,
    input  logic [WCODE_W-1:0]    slot_code_i,
    input  logic [WCODE_W-1:0]    data_code_i,
    input  logic [DELAY_W-1:0]    delay_i,
    output logic                  bad_o,
    output logic                  burst_o,
    output logic [SLOT_IDX_W-1:0] last_slot_o,
    output logic [BIT_IDX_W-1:0]  slot_w_o,
    output logic [BIT_IDX_W-1:0]  data_w_o
);

    localparam logic [WCODE_W-1:0]    MAX_CODE  = WCODE_W'(6);
    localparam logic [DELAY_W-1:0]    MAX_DELAY = DELAY_W'(2);
    localparam logic [SLOT_CNT_W-1:0] TOP_SLOTS = SLOT_CNT_W'(MAX_SLOTS);

    always_comb begin
        slot_w_o    = code_to_width(slot_code_i);
        data_w_o    = code_to_width(data_code_i);
        bad_o       = (slot_code_i > MAX_CODE) || (data_code_i > MAX_CODE)
                   || (data_code_i > slot_code_i)
                   || (slots_i == '0) || (slots_i > TOP_SLOTS)
                   || (delay_i > MAX_DELAY);
        burst_o     = (slots_i == SLOT_CNT_W'(1));
        last_slot_o = SLOT_IDX_W'(slots_i - SLOT_CNT_W'(1));
    end

endmodule

// File: rtl/tdm_slot_formatter.sv
module tdm_slot_formatter
    import tdm_ser_pkg::*;
(
    input  logic [SAMPLE_W-1:0]  raw_i,
    input  logic [BIT_IDX_W-1:0] slot_w_i,
    input  logic [BIT_IDX_W-1:0] data_w_i,
    input  logic                 right_i,
    input  logic                 lsb_i,
    input  logic [1:0]           pad_i,
    input  logic [PAD_SEL_W-1:0] pad_sel_i,
    output logic [SAMPLE_W-1:0]  img_o
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] slot_word;
    logic                pad_v;
    int                  sw_i;
    int                  dw_i;
    int                  off_i;

    // Build the slot word (MSB at sw-1), then order it so img_o[k] is sent k-th.
    always_comb begin
        sw_i  = int'(slot_w_i);
        dw_i  = int'(data_w_i);
        off_i = sw_i - dw_i;
        unique case (pad_mode_e'(pad_i))
            PAD_ONE:  pad_v = 1'b1;
            PAD_COPY: pad_v = raw_i[pad_sel_i];
            default:  pad_v = 1'b0;
        endcase
        slot_word = '0;
        for (int j = 0; j < SAMPLE_W; j++) begin
            if (j < sw_i) begin
                if (right_i) begin
                    slot_word[j] = (j < dw_i) ? raw_i[j] : pad_v;
                end else begin
                    slot_word[j] = (j >= off_i) ? raw_i[IDX_W'(j - off_i)] : pad_v;
                end
            end
        end
        img_o = '0;
        for (int k = 0; k < SAMPLE_W; k++) begin
            if (k < sw_i) begin
                img_o[k] = lsb_i ? slot_word[k] : slot_word[IDX_W'(sw_i - 1 - k)];
            end
        end
    end

endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  cfg_slots,
    input  logic [2:0]  cfg_slot_w,
    input  logic [2:0]  cfg_data_w,
    input  logic        cfg_right_just,
    input  logic        cfg_lsb_first,
    input  logic [1:0]  cfg_pad_mode,
    input  logic [4:0]  cfg_pad_sel,
    input  logic [1:0]  cfg_fs_delay,
    input  logic        s_valid,
    input  logic [31:0] s_data,
    output logic        s_ready,
    output logic        ser_out,
    output logic        fsync,
    output logic        cfg_err,
    output logic        underrun
);

    localparam logic [DELAY_W-1:0]   ONE_LEAD = DELAY_W'(1);
    localparam logic [BIT_IDX_W-1:0] ONE_BIT  = BIT_IDX_W'(1);

    ser_state_t st_q;
    ser_state_t st_d;

    logic                  cfg_bad;
    logic                  burst;
    logic [SLOT_IDX_W-1:0] last_slot;
    logic [BIT_IDX_W-1:0]  slot_w;
    logic [BIT_IDX_W-1:0]  data_w;
    logic [SAMPLE_W-1:0]   fmt_img;

    logic                  load;
    logic                  ready_c;
    logic                  last_bit;
    logic                  on_last_slot;
    logic                  frame_end_burst;
    logic [BIT_IDX_W-1:0]  bit_nx;
    logic [BIT_IDX_W-1:0]  fs_point;

    tdm_cfg_check u_cfg (
        .slots_i     (cfg_slots),
        .slot_code_i (cfg_slot_w),
        .data_code_i (cfg_data_w),
        .delay_i     (cfg_fs_delay),
        .bad_o       (cfg_bad),
        .burst_o     (burst),
        .last_slot_o (last_slot),
        .slot_w_o    (slot_w),
        .data_w_o    (data_w)
    );

    tdm_slot_formatter u_fmt (
        .raw_i     (s_data),
        .slot_w_i  (slot_w),
        .data_w_i  (data_w),
        .right_i   (cfg_right_just),
        .lsb_i     (cfg_lsb_first),
        .pad_i     (cfg_pad_mode),
        .pad_sel_i (cfg_pad_sel),
        .img_o     (fmt_img)
    );

    always_comb begin
        last_bit        = (st_q.bitn == slot_w - ONE_BIT);
        on_last_slot    = (st_q.slot == last_slot);
        frame_end_burst = burst && st_q.run && (st_q.lead == '0) && last_bit;
        bit_nx          = st_q.bitn + ONE_BIT;
        fs_point        = slot_w - BIT_IDX_W'(cfg_fs_delay);

        st_d     = st_q;
        st_d.fs  = 1'b0;
        st_d.sdo = 1'b0;
        st_d.err = cfg_bad;
        load     = 1'b0;
        ready_c  = 1'b0;

        if (cfg_bad) begin
            st_d.run  = 1'b0;
            st_d.lead = '0;
        end else if (!st_q.run || frame_end_burst) begin
            if (!burst || s_valid) begin
                st_d.run  = 1'b1;
                st_d.fs   = 1'b1;
                st_d.slot = '0;
                st_d.bitn = '0;
                if (cfg_fs_delay == '0) begin
                    load = 1'b1;
                end else begin
                    st_d.lead = cfg_fs_delay;
                end
            end else begin
                st_d.run  = 1'b0;
                st_d.lead = '0;
            end
        end else if (st_q.lead != '0) begin
            if (st_q.lead == ONE_LEAD) begin
                st_d.lead = '0;
                st_d.slot = '0;
                load      = 1'b1;
            end else begin
                st_d.lead = st_q.lead - ONE_LEAD;
            end
        end else if (!last_bit) begin
            st_d.bitn = bit_nx;
            st_d.sdo  = st_q.img[bit_nx[PAD_SEL_W-1:0]];
            st_d.fs   = !burst && (cfg_fs_delay != '0) && on_last_slot && (bit_nx == fs_point);
        end else begin
            st_d.slot = on_last_slot ? '0 : st_q.slot + SLOT_IDX_W'(1);
            load      = 1'b1;
            st_d.fs   = (cfg_fs_delay == '0) && on_last_slot;
        end

        if (load) begin
            ready_c   = 1'b1;
            st_d.bitn = '0;
            st_d.img  = s_valid ? fmt_img : '0;
            st_d.sdo  = s_valid & fmt_img[0];
            if (!s_valid) begin
                st_d.und = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready  = ready_c;
    assign ser_out  = st_q.sdo;
    assign fsync    = st_q.fs;
    assign cfg_err  = st_q.err;
    assign underrun = st_q.und;

    AST_FS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !fsync) else $error("fsync wider than one clock"); // R7
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!ser_out && !fsync)) else $error("output active under cfg error"); // R10
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun) else $error("underrun flag cleared"); // R11
    AST_LEAD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lead > ONE_LEAD) |-> !s_ready) else $error("ready during early lead-in"); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!ser_out && !fsync)) else $error("output active while idle"); // R8

endmodule

// File: tb/tdm_serializer_test.sv
module tdm_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  cfg_slots;
    logic [2:0]  cfg_slot_w;
    logic [2:0]  cfg_data_w;
    logic        cfg_right_just;
    logic        cfg_lsb_first;
    logic [1:0]  cfg_pad_mode;
    logic [4:0]  cfg_pad_sel;
    logic [1:0]  cfg_fs_delay;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready;
    logic        ser_out;
    logic        fsync;
    logic        cfg_err;
    logic        underrun;

    always #4 clk = ~clk;

    tdm_serializer uut (
        .clk(clk), .rst_n(rst_n), .cfg_slots(cfg_slots), .cfg_slot_w(cfg_slot_w),
        .cfg_data_w(cfg_data_w), .cfg_right_just(cfg_right_just), .cfg_lsb_first(cfg_lsb_first),
        .cfg_pad_mode(cfg_pad_mode), .cfg_pad_sel(cfg_pad_sel), .cfg_fs_delay(cfg_fs_delay),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .ser_out(ser_out),
        .fsync(fsync), .cfg_err(cfg_err), .underrun(underrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit        m_run;
    int        m_lead, m_slot, m_bit;
    bit [31:0] m_img;
    bit        e_sdo, e_fs, e_err, e_und;
    logic [31:0] pend[$];
    int        gap_len, gap_cnt;
    string     tag;

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int wid(logic [2:0] c);
        return 8 + 4 * int'(c);
    endfunction

    // R10: legality of the present configuration
    function automatic bit is_bad();
        return (cfg_slot_w > 6) || (cfg_data_w > 6) || (cfg_data_w > cfg_slot_w)
            || (cfg_slots == 0) || (cfg_slots > 32) || (cfg_fs_delay == 3);
    endfunction

    // R3-R6: sequence of bits to send, index k = k-th bit on the line
    function automatic bit [31:0] expect_bits(logic [31:0] raw);
        bit line[$];
        bit [31:0] r = '0;
        int sw = wid(cfg_slot_w);
        int dw = wid(cfg_data_w);
        bit pad = (cfg_pad_mode == 2'd1) ? 1'b1 : (cfg_pad_mode == 2'd2) ? raw[cfg_pad_sel] : 1'b0;
        if (!cfg_right_just) begin
            for (int i = dw - 1; i >= 0; i--) line.push_back(raw[i]);
            for (int i = 0; i < sw - dw; i++) line.push_back(pad);
        end else begin
            for (int i = 0; i < sw - dw; i++) line.push_back(pad);
            for (int i = dw - 1; i >= 0; i--) line.push_back(raw[i]);
        end
        for (int k = 0; k < sw; k++) r[k] = cfg_lsb_first ? line[sw - 1 - k] : line[k];
        return r;
    endfunction

    task automatic model_step(output bit rdy);
        int sw = wid(cfg_slot_w);
        int d  = int'(cfg_fs_delay);
        int ns = int'(cfg_slots);
        bit burst = (ns == 1);
        bit take_slot = 0;
        rdy = 0; e_fs = 0; e_sdo = 0; e_err = is_bad();
        if (e_err) begin
            m_run = 0; m_lead = 0;
        end else if (!m_run || (burst && m_lead == 0 && m_bit == sw - 1)) begin
            if (!burst || s_valid) begin
                m_run = 1; e_fs = 1; m_slot = 0; m_bit = 0;
                if (d == 0) take_slot = 1; else m_lead = d;
            end else begin
                m_run = 0; m_lead = 0;
            end
        end else if (m_lead > 0) begin
            if (m_lead == 1) begin m_lead = 0; m_slot = 0; take_slot = 1; end
            else m_lead--;
        end else if (m_bit < sw - 1) begin
            m_bit++;
            e_sdo = m_img[m_bit];
            if (!burst && d > 0 && m_slot == ns - 1 && m_bit == sw - d) e_fs = 1;
        end else begin
            m_slot = (m_slot == ns - 1) ? 0 : m_slot + 1;
            take_slot = 1;
            if (d == 0 && m_slot == 0) e_fs = 1;
        end
        if (take_slot) begin
            rdy = 1; m_bit = 0;
            if (s_valid) m_img = expect_bits(s_data);
            else begin m_img = '0; e_und = 1; end
            e_sdo = m_img[0];
        end
    endtask

    task automatic drive_inputs(bit taken);
        if (s_valid && !taken) return;
        if (taken) gap_cnt = gap_len;
        if (gap_cnt > 0) begin
            gap_cnt--; s_valid = 0;
        end else if (pend.size() > 0) begin
            s_valid = 1; s_data = pend[0];
        end else begin
            s_valid = 0; s_data = '0;
        end
    endtask

    task automatic step();
        bit rdy;
        bit take;
        #1;
        model_step(rdy);
        chk("R9", s_ready, rdy, "s_ready");
        take = rdy && s_valid;
        @(posedge clk);
        @(negedge clk);
        if (take) void'(pend.pop_front());
        chk(tag, ser_out, e_sdo, "ser_out");
        chk("R7", fsync, e_fs, "fsync");
        chk("R10", cfg_err, e_err, "cfg_err");
        chk("R11", underrun, e_und, "underrun");
        drive_inputs(take);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic start_case(string t, int slots, int swc, int dwc, bit rj, bit lsb,
                              int pad, int psel, int dly, int gap, int nsamp);
        tag = t;
        @(negedge clk);
        rst_n = 0;
        cfg_slots = 6'(slots); cfg_slot_w = 3'(swc); cfg_data_w = 3'(dwc);
        cfg_right_just = rj; cfg_lsb_first = lsb; cfg_pad_mode = 2'(pad);
        cfg_pad_sel = 5'(psel); cfg_fs_delay = 2'(dly);
        pend.delete();
        for (int i = 0; i < nsamp; i++) pend.push_back($urandom());
        gap_len = gap; gap_cnt = 0;
        s_valid = 0; s_data = '0;
        m_run = 0; m_lead = 0; m_slot = 0; m_bit = 0; m_img = '0;
        e_sdo = 0; e_fs = 0; e_err = 0; e_und = 0;
        repeat (2) @(negedge clk);
        chk("R12", ser_out, 1'b0, "ser_out in reset");
        chk("R12", fsync, 1'b0, "fsync in reset");
        chk("R12", cfg_err, 1'b0, "cfg_err in reset");
        chk("R12", underrun, 1'b0, "underrun in reset");
        rst_n = 1;
        drive_inputs(1'b0);
    endtask

    initial begin
        rst_n = 0; s_valid = 0; s_data = '0;
        // R2: 4 slots of 16 bits, full data, delay 1
        start_case("R2", 4, 2, 2, 0, 0, 0, 0, 1, 0, 200);
        run(400);
        // R4 / R5 / R6: 32-bit slot, 20-bit data, right-justified, LSB first, fill ones, delay 2
        start_case("R4", 3, 6, 3, 1, 1, 1, 0, 2, 0, 200);
        run(500);
        // R6: copy fill of bit 11, 24-bit slot, 12-bit data, delay 0
        start_case("R6", 2, 4, 1, 0, 0, 2, 11, 0, 0, 200);
        run(400);
        // R5: left-justified LSB-first with zero fill, delay 2
        start_case("R5", 2, 5, 2, 0, 1, 0, 0, 2, 0, 200);
        run(400);
        // R3: data narrower than slot, right-justified MSB first, fill mode 3 reads as zero
        start_case("R3", 3, 3, 0, 1, 0, 3, 0, 1, 0, 200);
        run(400);
        // R1: 32 slots of 8 bits, delay 0
        start_case("R1", 32, 0, 0, 0, 0, 1, 0, 0, 0, 300);
        run(700);
        // R8: burst, gaps between samples, delay 1 then delay 0
        start_case("R8", 1, 4, 4, 0, 0, 0, 0, 1, 13, 30);
        run(600);
        start_case("R8", 1, 1, 0, 1, 1, 2, 3, 0, 5, 30);
        run(600);
        // R11: TDM with a sparse supply, then dry
        start_case("R11", 2, 2, 1, 0, 0, 0, 0, 1, 40, 8);
        run(500);
        // R10: legal TDM run, faults injected mid-frame, then recovery
        start_case("R10", 3, 2, 2, 0, 0, 0, 0, 1, 0, 300);
        run(70);
        cfg_data_w = 3'd5;
        run(20);
        cfg_data_w = 3'd2;
        run(90);
        cfg_fs_delay = 2'd3;
        run(10);
        cfg_fs_delay = 2'd2;
        run(60);
        cfg_slots = 6'd0;
        run(8);
        cfg_slots = 6'd33;
        run(8);
        cfg_slots = 6'd3;
        cfg_slot_w = 3'd7;
        run(8);
        cfg_slot_w = 3'd2;
        run(120);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired, run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule